// File: doc/BRIEF.md
# Register-Mapped Serial Port with Byte Queues

This block is a byte-oriented asynchronous serial port that a processor drives through seven 32-bit registers on a simple strobe bus. Bytes written to the transmit data word go into an eight-entry queue. The transmit engine drains that queue onto the serial output as frames of one start bit, eight data bits sent least significant bit first, and one stop bit. The receive engine watches the serial input for a start edge and samples each bit at its centre. It stores every well-formed byte in a second eight-entry queue, where software collects it through the receive data word.

Queue status is carried in bit 31 of the data words. A single read of the receive word therefore both tests for data and removes a byte. A single read of the transmit word tells software whether there is room. The bit period is the clock period multiplied by the divisor plus one. Two level flags compare queue fill against programmable thresholds. They are gated by an enable mask into one interrupt line.

The bus is a plain request strobe with no back-pressure. A request is accepted in the cycle `bus_sel` is high. Read data is valid in that same cycle, and the effects of the access are seen from the next cycle on. The serial pins carry no handshake.

Top module: `uart_fifo_port`

## Requirements
- R1: After reset the divisor reads 3. `ser_tx` is high and `irq` is low. Both enables, both thresholds and the interrupt mask are zero. A read of the receive word returns 0x8000_0000.
- R2: Word index 0 selects txdata, 1 rxdata, 2 txctrl, 3 rxctrl, 4 ie, 5 ip and 6 div. txctrl and rxctrl read back bit 0 (enable) and bits 18:16 (threshold), with every other bit zero. ie reads back bits 1:0. div reads back its 16 bits.
- R3: A write to txdata queues bits 7:0 when the transmit queue holds fewer than 8 bytes, and is ignored when it is full. A read of txdata returns 0x8000_0000 when the queue is full and 0 otherwise.
- R4: A read of rxdata with bytes queued returns the oldest byte in bits 7:0, with all other bits zero, and removes it. With the queue empty the read returns 0x8000_0000 and changes nothing.
- R5: While txctrl bit 0 is set, queued bytes are sent in order. Each frame is start bit 0, data least significant bit first, then stop bit 1, and each bit lasts div+1 clocks. While the transmitter is disabled, or has nothing to send, `ser_tx` stays high.
- R6: While rxctrl bit 0 is set, a high-to-low transition on `ser_rx` starts a frame, and each bit is sampled at its centre. A frame whose stop bit reads 0 is discarded. With the receiver disabled, incoming frames are not stored.
- R7: ip bit 0 is 1 when the transmit queue holds fewer bytes than txctrl[18:16]. ip bit 1 is 1 when the receive queue holds more bytes than rxctrl[18:16]. Writes to ip have no effect.
- R8: `irq` is the OR of (ip AND ie) over bits 1:0.
- R9: A byte that completes while the receive queue holds 8 bytes is dropped. The 8 queued bytes are kept unchanged.
- R10: With div set to 0, each transmitted bit lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per high cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt request |

## Verification
Read data is combinational, so the bench samples it one nanosecond after driving a read at the falling edge and before the rising edge that commits any pop. A txdata write lands in the queue at the next rising edge, and the frame start appears one edge later. The bench therefore searches for the falling start bit and then samples every falling edge of the frame, which pins each bit to exactly div+1 clocks. A received byte reaches the queue about half a bit plus three clocks after the start of the stop bit. For that reason every frame the bench sends is followed by two idle bit periods before ip, `irq` or rxdata is inspected.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [2:0] {
    W_TXDATA = 3'd0,
    W_RXDATA = 3'd1,
    W_TXCTRL = 3'd2,
    W_RXCTRL = 3'd3,
    W_IE     = 3'd4,
    W_IP     = 3'd5,
    W_DIV    = 3'd6
  } reg_word_e;

  localparam int THR_LSB = 16;
  localparam int EMPTY_FULL_BIT = 31;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             has_data,
  input  logic [7:0]       data,
  output logic             take,
  output logic             txd,
  output logic             busy
);
  logic [9:0]       shreg;
  logic [3:0]       bit_idx;
  logic [DIV_W-1:0] tmr;

  assign take = !busy && en && has_data;
  assign txd  = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '1;
      bit_idx <= '0;
      tmr     <= '0;
    end else if (!busy) begin
      if (take) begin
        shreg   <= {1'b1, data, 1'b0};
        busy    <= 1'b1;
        bit_idx <= '0;
        tmr     <= div;
      end
    end else if (tmr == '0) begin
      tmr <= div;
      if (bit_idx == 4'd9) begin
        busy <= 1'b0;
      end else begin
        shreg   <= {1'b1, shreg[9:1]};
        bit_idx <= bit_idx + 1'b1;
      end
    end else begin
      tmr <= tmr - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             got_byte,
  output logic [7:0]       data
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e        state;
  logic             sync1, sync2, last;
  logic [2:0]       bit_idx;
  logic [DIV_W-1:0] tmr;
  logic [7:0]       shreg;
  logic             fall;

  assign fall     = last && !sync2;
  assign got_byte = en && (state == S_STOP) && (tmr == '0) && sync2;
  assign data     = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      last  <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_idx <= '0;
      tmr     <= '0;
      shreg   <= '0;
    end else if (!en) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (fall) begin
          state <= S_START;
          tmr   <= div >> 1;
        end
        S_START: if (tmr == '0) begin
          if (!sync2) begin
            state   <= S_DATA;
            tmr     <= div;
            bit_idx <= '0;
          end else begin
            state <= S_IDLE;
          end
        end else tmr <= tmr - 1'b1;
        S_DATA: if (tmr == '0) begin
          shreg <= {sync2, shreg[7:1]};
          tmr   <= div;
          if (bit_idx == 3'd7) state <= S_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end else tmr <= tmr - 1'b1;
        default: if (tmr == '0) state <= S_IDLE;
                 else tmr <= tmr - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int DIV_RESET = 3,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ser_tx,
  input  logic        ser_rx,
  output logic        irq
);
  logic             tx_en, rx_en;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [1:0]       ie_q, ip;
  logic [DIV_W-1:0] div_q;

  logic          wr, rd;
  logic          tx_push, tx_pop, tx_full, tx_empty, tx_busy;
  logic [7:0]    tx_dout;
  logic [CW-1:0] tx_count;
  logic          rx_push, rx_pop, rx_full, rx_empty, rx_got;
  logic [7:0]    rx_byte, rx_dout;
  logic [CW-1:0] rx_count;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  assign tx_push = wr && (bus_word == W_TXDATA) && !tx_full;
  assign rx_pop  = rd && (bus_word == W_RXDATA) && !rx_empty;
  assign rx_push = rx_got && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      tx_thr <= '0;
      rx_thr <= '0;
      ie_q   <= '0;
      div_q  <= DIV_W'(DIV_RESET);
    end else if (wr) begin
      case (bus_word)
        W_TXCTRL: begin
          tx_en  <= bus_wdata[0];
          tx_thr <= bus_wdata[THR_LSB +: THR_W];
        end
        W_RXCTRL: begin
          rx_en  <= bus_wdata[0];
          rx_thr <= bus_wdata[THR_LSB +: THR_W];
        end
        W_IE:  ie_q  <= bus_wdata[1:0];
        W_DIV: div_q <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  assign ip[0] = tx_count < CW'(tx_thr);
  assign ip[1] = rx_count > CW'(rx_thr);
  assign irq   = |(ip & ie_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_word)
      W_TXDATA: bus_rdata[EMPTY_FULL_BIT] = tx_full;
      W_RXDATA: if (rx_empty) bus_rdata[EMPTY_FULL_BIT] = 1'b1;
                else bus_rdata[7:0] = rx_dout;
      W_TXCTRL: begin
        bus_rdata[0] = tx_en;
        bus_rdata[THR_LSB +: THR_W] = tx_thr;
      end
      W_RXCTRL: begin
        bus_rdata[0] = rx_en;
        bus_rdata[THR_LSB +: THR_W] = rx_thr;
      end
      W_IE:  bus_rdata[1:0] = ie_q;
      W_IP:  bus_rdata[1:0] = ip;
      W_DIV: bus_rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  uart_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_tx_engine #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .div(div_q),
    .has_data(!tx_empty), .data(tx_dout), .take(tx_pop),
    .txd(ser_tx), .busy(tx_busy)
  );

  uart_rx_engine #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div_q),
    .rxd(ser_rx), .got_byte(rx_got), .data(rx_byte)
  );
endmodule

// File: rtl/uart_fifo_port_chk.sv
module uart_fifo_port_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [2:0]    bus_word,
  input logic [31:0]   bus_rdata,
  input logic          ser_tx,
  input logic          irq,
  input logic [1:0]    ie_q,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_pop,
  input logic          tx_busy
);
  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_word == 3'd0 && tx_count == CW'(DEPTH) && !tx_pop)
    |=> tx_count == CW'(DEPTH));

  p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_word == 3'd0)
    |-> bus_rdata[31] == (tx_count == CW'(DEPTH)));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_word == 3'd1 && rx_count == '0)
    |-> bus_rdata == 32'h8000_0000);

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_tx);

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q != 2'b00));

  p_rx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));
endmodule

bind uart_fifo_port uart_fifo_port_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_word(bus_word), .bus_rdata(bus_rdata), .ser_tx(ser_tx), .irq(irq),
  .ie_q(ie_q), .tx_count(tx_count), .rx_count(rx_count),
  .tx_pop(tx_pop), .tx_busy(tx_busy)
);

// File: tb/test_uart_fifo_port.sv
`timescale 1ns/1ps
module test_uart_fifo_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_tx;
  logic        ser_rx = 1'b1;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_port i_uart_fifo_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_word = w;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Samples every falling edge of one frame, so each bit must last p clocks.
  task automatic capture_tx(input int p, output logic [7:0] b, output bit ok);
    int guard = 0;
    ok = 1'b1;
    b = '0;
    @(negedge clk);
    while (ser_tx !== 1'b0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) begin
      ok = 1'b0;
      return;
    end
    for (int s = 0; s < 10 * p; s++) begin
      int k;
      if (s > 0) @(negedge clk);
      k = s / p;
      if (k >= 1 && k <= 8) begin
        if (s % p == 0) b[k-1] = ser_tx;
        else if (ser_tx !== b[k-1]) ok = 1'b0;
      end else if (ser_tx !== (k == 9)) ok = 1'b0;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv, input int p);
    logic [9:0] f;
    f = {stopv, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ser_rx = f[i];
      repeat (p - 1) @(negedge clk);
    end
    @(negedge clk);
    ser_rx = 1'b1;
    repeat (2 * p) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(3'd6, d);  chk("R1 div reset", d, 32'd3);
    chk("R1 tx line idle", {31'b0, ser_tx}, 32'd1);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    bus_read(3'd1, d);  chk("R1 R4 rxdata empty", d, 32'h8000_0000);
    bus_read(3'd0, d);  chk("R3 txdata not full", d, 32'd0);
    bus_read(3'd2, d);  chk("R1 txctrl reset", d, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_write(3'd2, 32'hFFF7_FFFE); bus_read(3'd2, d); chk("R2 txctrl fields", d, 32'h0007_0000);
    bus_write(3'd3, 32'h0002_0000); bus_read(3'd3, d); chk("R2 rxctrl fields", d, 32'h0002_0000);
    bus_write(3'd4, 32'hFFFF_FFFF); bus_read(3'd4, d); chk("R2 ie fields", d, 32'd3);
    bus_write(3'd5, 32'h0000_0000); bus_read(3'd5, d); chk("R7 ip write ignored", d, 32'd1);
    chk("R8 irq from tx level", {31'b0, irq}, 32'd1);
    bus_write(3'd4, 32'd0);
    #1 chk("R8 irq masked", {31'b0, irq}, 32'd0);
    bus_write(3'd6, 32'hABCD_0005); bus_read(3'd6, d); chk("R2 div fields", d, 32'd5);
  endtask

  task automatic t_tx_queue;
    logic [31:0] d;
    logic [7:0] b;
    bit ok;
    int bad;
    bus_write(3'd6, 32'd3);
    bus_write(3'd2, 32'h0003_0000);
    bus_read(3'd5, d); chk("R7 tx level below threshold", d, 32'd1);
    for (int i = 0; i < 8; i++) bus_write(3'd0, 32'hFFFF_FF00 | (i * 8'h1D + 8'h07));
    bus_read(3'd0, d); chk("R3 txdata full flag", d, 32'h8000_0000);
    bus_read(3'd5, d); chk("R7 tx level above threshold", d, 32'd0);
    bus_write(3'd0, 32'h0000_00EE);
    bus_write(3'd2, 32'h0003_0001);
    for (int i = 0; i < 8; i++) begin
      capture_tx(4, b, ok);
      chk("R5 frame shape", {31'b0, ok}, 32'd1);
      chk("R3 R5 byte order", {24'b0, b}, 32'(i * 8'h1D + 8'h07));
    end
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (ser_tx !== 1'b1) bad++;
    end
    chk("R3 write when full dropped", bad, 0);
    bus_read(3'd0, d); chk("R3 txdata drained", d, 32'd0);
  endtask

  task automatic t_tx_disabled;
    int bad = 0;
    logic [7:0] b;
    bit ok;
    bus_write(3'd2, 32'd0);
    bus_write(3'd0, 32'h5A);
    repeat (80) begin
      @(negedge clk);
      if (ser_tx !== 1'b1) bad++;
    end
    chk("R5 disabled line stays high", bad, 0);
    bus_write(3'd2, 32'd1);
    capture_tx(4, b, ok);
    chk("R5 held byte sent on enable", {23'b0, ok, b}, 32'h15A);
  endtask

  task automatic t_div0;
    logic [7:0] b;
    bit ok;
    bus_write(3'd6, 32'd0);
    bus_write(3'd0, 32'hA5);
    capture_tx(1, b, ok);
    chk("R10 one clock per bit", {23'b0, ok, b}, 32'h1A5);
    repeat (4) @(negedge clk);
    bus_write(3'd6, 32'd3);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    bus_write(3'd2, 32'd1);
    bus_write(3'd3, 32'h0001_0001);
    bus_write(3'd4, 32'd2);
    send_rx(8'h3C, 1'b1, 4);
    bus_read(3'd5, d); chk("R7 rx level at threshold", d, 32'd0);
    chk("R8 irq low", {31'b0, irq}, 32'd0);
    send_rx(8'hC3, 1'b1, 4);
    bus_read(3'd5, d); chk("R7 rx level above threshold", d, 32'd2);
    chk("R8 irq high", {31'b0, irq}, 32'd1);
    bus_read(3'd1, d); chk("R4 R6 first byte", d, 32'h3C);
    bus_read(3'd1, d); chk("R4 R6 second byte", d, 32'hC3);
    bus_read(3'd1, d); chk("R4 empty after pops", d, 32'h8000_0000);
    bus_read(3'd1, d); chk("R4 empty read repeat", d, 32'h8000_0000);
    send_rx(8'h55, 1'b0, 4);
    bus_read(3'd1, d); chk("R6 bad stop discarded", d, 32'h8000_0000);
    bus_write(3'd3, 32'h0001_0000);
    send_rx(8'h81, 1'b1, 4);
    bus_write(3'd3, 32'h0001_0001);
    bus_read(3'd1, d); chk("R6 disabled receiver stores nothing", d, 32'h8000_0000);
    bus_write(3'd4, 32'd0);
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    bus_write(3'd3, 32'h0007_0001);
    for (int i = 0; i < 9; i++) send_rx(8'(i * 8'h11 + 8'h02), 1'b1, 4);
    bus_read(3'd5, d); chk("R7 rx level full", d, 32'd2);
    chk("R8 irq masked", {31'b0, irq}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      bus_read(3'd1, d); chk("R9 kept bytes", d, 32'(8'(i * 8'h11 + 8'h02)));
    end
    bus_read(3'd1, d); chk("R9 ninth byte dropped", d, 32'h8000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_tx_queue();
    t_tx_disabled();
    t_div0();
    t_rx();
    t_rx_full();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule